// File: doc/BRIEF.md
# Layered Parity-Matrix Address Generator

This block rebuilds, on demand, the positions of the ones in the information part of a quasi-cyclic parity check matrix, one layer at a time. A layered decoder only needs the rows and columns of the layer it is working on. The block therefore keeps nothing per nonzero entry. It reads a compact table that stores, for each square block of side 360, four 9-bit shift codes, and it expands those codes into a stream of (column, row) pairs.

A request pulses `start` with a layer number. The runtime counts of layers and of blocks per layer come with the same pulse; they depend on code rate and frame size. The block addresses the external shift table by layer and block number and reads it combinationally. It emits one pair per cycle for every one in each block. A block whose four codes are all sentinels gets a single-cycle zero marker in place of pairs. `layer_done` is raised together with the final item of the layer.

Top module: `qc_addr_gen`

## Requirements
- R1: After reset, `busy`, `out_valid`, `out_zero` and `layer_done` are all low.
- R2: For an active shift code s and an in-block column c, the row output is (s + c) mod 360. It wraps to small values when s + c is 360 or more.
- R3: The column output is 360 × (block number within the layer) + c. Within one shift code, c runs from 0 to 359 in ascending order, one value per cycle.
- R4: Block data holds four 9-bit fields; field i is bits [9i+8:9i]. Fields are expanded in order i = 0, 1, 2, 3. A field whose value is 360 or greater is a sentinel and is skipped without spending a cycle, so that from the first item of a layer to its last, every cycle carries either a pair or a zero marker.
- R5: A block whose four fields are all sentinels produces exactly one cycle with `out_zero` high and `out_valid` low.
- R6: `layer_done` is high for exactly one cycle, in the cycle that carries the layer's last pair or zero marker, and `busy` is low in that cycle.
- R7: A `start` pulse while `busy` is high is ignored: the stream of the running layer is unchanged.
- R8: A `start` pulse is ignored when `layer_idx` is not below `num_layers`, or when `num_subs` is zero or above the block-count bound; in that case `busy` stays low and nothing is emitted.
- R9: Only blocks 0 to `num_subs`−1 of the selected layer are walked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to expand one layer |
| layer_idx | input | 2 | Layer to expand |
| num_layers | input | 3 | Number of layers in use |
| num_subs | input | 3 | Blocks per layer in use |
| tbl_layer | output | 2 | Shift table layer address |
| tbl_sub | output | 2 | Shift table block address |
| tbl_fields | input | 36 | Four 9-bit shift fields of the addressed block |
| busy | output | 1 | A layer is being expanded |
| out_valid | output | 1 | `out_col`/`out_row` carry a nonzero position |
| out_col | output | 11 | Global column of the position |
| out_row | output | 9 | Row within the block |
| out_zero | output | 1 | Current block is all zeros |
| layer_done | output | 1 | Last item of the layer |

## Verification
The hardest case to reach is the seam between fields and between blocks. There the sentinel skip must land on the next live field, or on the next block's first live field, with no gap cycle. A zero block must also appear first or last in a layer, where it coincides with the done flag. The shift table in the bench holds sentinels in the middle and last field positions, the boundary sentinel value 360, zero blocks at both ends of a layer, a fully zero layer and shifts near 359 that wrap. The monitor flags any idle cycle inside a layer's stream.

// File: rtl/qc_pkg.sv
package qc_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } qc_state_e;
endpackage

// File: rtl/qc_field_pick.sv
module qc_field_pick #(
  parameter int NF  = 4,
  parameter int SW  = 9,
  parameter int BLK = 360,
  localparam int IW = $clog2(NF),
  localparam int FW = NF * SW
) (
  input  logic [FW-1:0] fields,
  input  logic [IW-1:0] from_idx,
  output logic          any_vld,
  output logic          cur_ok,
  output logic [IW-1:0] cur_idx,
  output logic [SW-1:0] cur_shift,
  output logic          more
);
  logic [NF-1:0] vld;

  for (genvar g = 0; g < NF; g++) begin : g_vld
    assign vld[g] = (fields[g*SW +: SW] < SW'(BLK));
  end

  assign any_vld = |vld;

  always_comb begin
    cur_ok  = 1'b0;
    cur_idx = '0;
    more    = 1'b0;
    for (int i = 0; i < NF; i++) begin
      if (vld[i] && (i >= int'(from_idx))) begin
        if (!cur_ok) begin
          cur_ok  = 1'b1;
          cur_idx = IW'(i);
        end else begin
          more = 1'b1;
        end
      end
    end
  end

  assign cur_shift = fields[cur_idx*SW +: SW];
endmodule

// File: rtl/qc_row_calc.sv
module qc_row_calc #(
  parameter int BLK = 360,
  parameter int SW  = 9,
  localparam int CW   = $clog2(BLK),
  localparam int SUMW = ((SW > CW) ? SW : CW) + 1
) (
  input  logic [SW-1:0] shift,
  input  logic [CW-1:0] col,
  output logic [CW-1:0] row
);
  logic [SUMW-1:0] sum;

  always_comb begin
    sum = SUMW'(shift) + SUMW'(col);
    if (sum >= SUMW'(BLK)) begin
      row = CW'(sum - SUMW'(BLK));
    end else begin
      row = CW'(sum);
    end
  end

  // R2
  always_comb begin
    if ((shift < SW'(BLK)) && (col < CW'(BLK))) begin
      row_range_chk: assert (row < CW'(BLK));
    end
  end
endmodule

// File: rtl/qc_addr_gen.sv
module qc_addr_gen #(
  parameter int BLK        = 360,
  parameter int SW         = 9,
  parameter int NF         = 4,
  parameter int MAX_LAYERS = 4,
  parameter int MAX_SUBS   = 4,
  localparam int LW   = $clog2(MAX_LAYERS),
  localparam int NLW  = $clog2(MAX_LAYERS + 1),
  localparam int SUBW = $clog2(MAX_SUBS),
  localparam int NSW  = $clog2(MAX_SUBS + 1),
  localparam int CW   = $clog2(BLK),
  localparam int GCW  = $clog2(MAX_SUBS * BLK),
  localparam int IW   = $clog2(NF),
  localparam int FW   = NF * SW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [LW-1:0]   layer_idx,
  input  logic [NLW-1:0]  num_layers,
  input  logic [NSW-1:0]  num_subs,
  output logic [LW-1:0]   tbl_layer,
  output logic [SUBW-1:0] tbl_sub,
  input  logic [FW-1:0]   tbl_fields,
  output logic            busy,
  output logic            out_valid,
  output logic [GCW-1:0]  out_col,
  output logic [CW-1:0]   out_row,
  output logic            out_zero,
  output logic            layer_done
);
  import qc_pkg::*;

  qc_state_e       state_q, state_d;
  logic [LW-1:0]   layer_q, layer_d;
  logic [SUBW-1:0] sub_q, sub_d;
  logic [NSW-1:0]  nsub_q, nsub_d;
  logic [IW-1:0]   fld_q, fld_d;
  logic [CW-1:0]   col_q, col_d;
  logic            vld_d, zero_d, done_d;
  logic [GCW-1:0]  ocol_d;
  logic [CW-1:0]   orow_d;

  logic            any_vld, cur_ok, more, last_sub, start_ok;
  logic [IW-1:0]   cur_idx;
  logic [SW-1:0]   cur_shift;
  logic [CW-1:0]   row_val;

  qc_field_pick #(.NF(NF), .SW(SW), .BLK(BLK)) u_pick (
    .fields    (tbl_fields),
    .from_idx  (fld_q),
    .any_vld   (any_vld),
    .cur_ok    (cur_ok),
    .cur_idx   (cur_idx),
    .cur_shift (cur_shift),
    .more      (more)
  );

  qc_row_calc #(.BLK(BLK), .SW(SW)) u_row (
    .shift (cur_shift),
    .col   (col_q),
    .row   (row_val)
  );

  assign tbl_layer = layer_q;
  assign tbl_sub   = sub_q;
  assign busy      = (state_q == ST_RUN);
  assign last_sub  = ((NSW'(sub_q) + NSW'(1)) == nsub_q);
  assign start_ok  = start && (NLW'(layer_idx) < num_layers) &&
                     (num_subs != '0) && (num_subs <= NSW'(MAX_SUBS));

  always_comb begin
    state_d = state_q;
    layer_d = layer_q;
    sub_d   = sub_q;
    nsub_d  = nsub_q;
    fld_d   = fld_q;
    col_d   = col_q;
    vld_d   = 1'b0;
    zero_d  = 1'b0;
    done_d  = 1'b0;
    ocol_d  = out_col;
    orow_d  = out_row;
    case (state_q)
      ST_IDLE: begin
        if (start_ok) begin
          state_d = ST_RUN;
          layer_d = layer_idx;
          nsub_d  = num_subs;
          sub_d   = '0;
          fld_d   = '0;
          col_d   = '0;
        end
      end
      default: begin
        logic advance;
        advance = 1'b0;
        if (!any_vld) begin
          zero_d  = 1'b1;
          advance = 1'b1;
        end else begin
          vld_d  = 1'b1;
          ocol_d = GCW'(sub_q) * GCW'(BLK) + GCW'(col_q);
          orow_d = row_val;
          if (col_q == CW'(BLK - 1)) begin
            col_d = '0;
            if (more) begin
              fld_d = cur_idx + IW'(1);
            end else begin
              advance = 1'b1;
            end
          end else begin
            col_d = col_q + CW'(1);
          end
        end
        if (advance) begin
          fld_d = '0;
          col_d = '0;
          if (last_sub) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            sub_d = sub_q + SUBW'(1);
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      layer_q    <= '0;
      sub_q      <= '0;
      nsub_q     <= '0;
      fld_q      <= '0;
      col_q      <= '0;
      out_valid  <= 1'b0;
      out_zero   <= 1'b0;
      layer_done <= 1'b0;
      out_col    <= '0;
      out_row    <= '0;
    end else begin
      state_q    <= state_d;
      layer_q    <= layer_d;
      sub_q      <= sub_d;
      nsub_q     <= nsub_d;
      fld_q      <= fld_d;
      col_q      <= col_d;
      out_valid  <= vld_d;
      out_zero   <= zero_d;
      layer_done <= done_d;
      if (vld_d) begin
        out_col <= ocol_d;
        out_row <= orow_d;
      end
    end
  end

  // R4
  field_found_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && any_vld) |-> cur_ok);

  // R5
  zero_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_zero));

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    layer_done |-> !busy);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    layer_done |=> !layer_done);

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (tbl_layer == $past(tbl_layer)));

  // R8
  bad_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && (NLW'(layer_idx) >= num_layers)) |=> !busy);
endmodule

// File: tb/qc_addr_gen_tb.sv
module qc_addr_gen_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        zero;
    logic [10:0] col;
    logic [8:0]  row;
    logic        done;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  layer_idx;
  logic [2:0]  num_layers;
  logic [2:0]  num_subs;
  logic [1:0]  tbl_layer;
  logic [1:0]  tbl_sub;
  logic [35:0] tbl_fields;
  logic        busy, out_valid, out_zero, layer_done;
  logic [10:0] out_col;
  logic [8:0]  out_row;

  logic [35:0] tbl [0:3][0:3];
  item_t       exp_q[$];
  int          n_chk = 0;
  int          n_fail = 0;
  logic        active = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign tbl_fields = tbl[tbl_layer][tbl_sub];

  qc_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .layer_idx(layer_idx),
    .num_layers(num_layers), .num_subs(num_subs), .tbl_layer(tbl_layer),
    .tbl_sub(tbl_sub), .tbl_fields(tbl_fields), .busy(busy),
    .out_valid(out_valid), .out_col(out_col), .out_row(out_row),
    .out_zero(out_zero), .layer_done(layer_done)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic logic [35:0] pack4(input int a, input int b, input int c, input int d);
    return {9'(d), 9'(c), 9'(b), 9'(a)};
  endfunction

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid || out_zero) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 unexpected output", int'(out_col), -1);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          chk(out_zero == e.zero, "R5 zero marker", int'(out_zero), int'(e.zero));
          if (!e.zero) begin
            chk(out_col == e.col, "R3 column", int'(out_col), int'(e.col));
            chk(out_row == e.row, "R2 row", int'(out_row), int'(e.row));
          end
          chk(layer_done == e.done, "R6 done flag", int'(layer_done), int'(e.done));
          active = !e.done;
        end
      end else if (active) begin
        chk(1'b0, "R4 gap cycle in stream", 0, 1);
      end
      if (layer_done) chk(!busy, "R6 busy with done", int'(busy), 0);
    end
  end

  task automatic push_layer(input int l, input int ns);
    item_t t;
    for (int s = 0; s < ns; s++) begin
      int nlive;
      nlive = 0;
      for (int f = 0; f < 4; f++) begin
        int sh;
        sh = int'(tbl[l][s][f*9 +: 9]);
        if (sh < 360) begin
          nlive++;
          for (int c = 0; c < 360; c++) begin
            t.zero = 1'b0;
            t.col  = 11'(s * 360 + c);
            t.row  = 9'((sh + c) % 360);
            t.done = 1'b0;
            exp_q.push_back(t);
          end
        end
      end
      if (nlive == 0) begin
        t = '0;
        t.zero = 1'b1;
        exp_q.push_back(t);
      end
    end
    t = exp_q.pop_back();
    t.done = 1'b1;
    exp_q.push_back(t);
  endtask

  task automatic run_layer(input int l, input int nl, input int ns,
                           input int poke_at, input string tag);
    int guard;
    push_layer(l, ns);
    @(negedge clk);
    layer_idx = 2'(l); num_layers = 3'(nl); num_subs = 3'(ns); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy, {tag, " busy after start"}, int'(busy), 1);
    guard = 0;
    while (busy && guard < 20000) begin
      @(negedge clk);
      guard++;
      if (guard == poke_at) begin
        // R7: start while busy, different layer
        layer_idx = 2'((l + 2) % 4); num_subs = 3'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    end
    @(negedge clk);
    chk(exp_q.size() == 0, {tag, " all items seen"}, exp_q.size(), 0);
    exp_q.delete();
    active = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    // layer 0: identity, middle sentinel, boundary-sentinel zero block, wrap
    tbl[0][0] = pack4(0, 511, 511, 511);
    tbl[0][1] = pack4(5, 360, 100, 200);
    tbl[0][2] = pack4(360, 511, 400, 360);
    tbl[0][3] = pack4(359, 511, 511, 1);
    // layer 1: zero first and last, only field 3 live
    tbl[1][0] = pack4(511, 511, 511, 511);
    tbl[1][1] = pack4(358, 511, 511, 511);
    tbl[1][2] = pack4(511, 511, 511, 7);
    tbl[1][3] = pack4(360, 360, 360, 360);
    // layer 2: four live fields
    tbl[2][0] = pack4(1, 2, 3, 4);
    tbl[2][1] = pack4(300, 0, 359, 180);
    tbl[2][2] = pack4(9, 9, 9, 9);
    tbl[2][3] = pack4(9, 9, 9, 9);
    // layer 3: entirely zero
    for (int s = 0; s < 4; s++) tbl[3][s] = pack4(511, 511, 511, 511);

    rst_n = 1'b0; start = 1'b0; layer_idx = '0; num_layers = 3'd4; num_subs = 3'd4;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy, "R1 busy", int'(busy), 0);
    chk(!out_valid, "R1 out_valid", int'(out_valid), 0);
    chk(!out_zero, "R1 out_zero", int'(out_zero), 0);
    chk(!layer_done, "R1 layer_done", int'(layer_done), 0);

    run_layer(0, 4, 4, 50, "R7 R2 R3 R4 layer0");
    run_layer(1, 4, 4, 0, "R5 R6 layer1");
    run_layer(2, 4, 2, 0, "R9 layer2 two blocks");
    run_layer(3, 4, 4, 0, "R5 layer3 all zero");
    run_layer(3, 4, 1, 0, "R9 R6 single zero block");

    // R8: out-of-range layer, zero block count, too many blocks
    @(negedge clk);
    layer_idx = 2'd3; num_layers = 3'd2; num_subs = 3'd4; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk(!busy, "R8 layer out of range", int'(busy), 0);
    layer_idx = 2'd0; num_layers = 3'd4; num_subs = 3'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk(!busy, "R8 zero block count", int'(busy), 0);
    num_subs = 3'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy, "R8 block count above bound", int'(busy), 0);
    chk(!out_valid && !out_zero, "R8 no output", int'(out_valid), 0);

    run_layer(0, 1, 3, 0, "R9 R3 after ignored starts");

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule